// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes configuration words from a host over three pins: a serial clock, a serial data line and a load-enable strobe. It samples all three on a faster system clock. A 32-bit shift register captures the data line on each rising edge of the serial clock, most-significant bit first. When load enable rises, the block copies the accumulated word into one of six parallel control registers. The word's three lowest bits select the register. Each control register drives a parallel output bus, and a one-cycle load strobe tells downstream logic which register has just changed.

The block also produces the global power-down and charge-pump tri-state controls. The chip-enable pin drives both. A software power-down bit in one of the control registers can also force power-down.

Top module: `cfg_serial_loader`

## Requirements
- R1: On each rising edge of the serial clock, the data line is shifted into the shift register, most-significant bit first. After 32 edges, the first bit sent sits in bit 31 and the last bit sent sits in bit 0.
- R2: Only a rising edge of load enable commits a word. Serial clock edges while load enable is high still shift data, but they commit nothing until the next rising edge of load enable.
- R3: Bits [2:0] of the committed word select the destination register, numbered 0 to 5. The whole 32-bit word is stored, address bits included. Register k appears on `cfg_flat_o[32*k+31:32*k]`.
- R4: A commit changes only the selected register. All other registers keep their values.
- R5: A word whose bits [2:0] are 6 or 7 is ignored. No register changes and no load strobe is raised.
- R6: `load_stb_o[k]` is high for exactly one system cycle: the first cycle in which the new contents of register k are visible. At most one strobe bit is high at a time. A write becomes visible three system cycles after the load-enable pin is first sampled high.
- R7: After synchronization, a low chip enable drives `cp_tristate_o` high and `pwr_down_o` high. A high chip enable releases `cp_tristate_o`. `pwr_down_o` is also high whenever bit 5 of register 2 is set.
- R8: After reset, all registers are zero, no strobe is raised, and both `pwr_down_o` and `cp_tristate_o` are high until chip enable is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock pin |
| ser_dat_i | input | 1 | Serial data pin |
| ser_le_i | input | 1 | Load-enable pin |
| chip_en_i | input | 1 | Chip-enable pin |
| cfg_flat_o | output | 192 | Six 32-bit control registers, with register 0 in the lowest bits |
| load_stb_o | output | 6 | One-cycle update strobe for each register |
| pwr_down_o | output | 1 | Global power-down |
| cp_tristate_o | output | 1 | Charge-pump tri-state control |

## Verification
Words are written to every valid address with distinct patterns, including alternating-bit values. This separates a correct MSB-first order and address decode from bit-reversed or misrouted stores, and shows that neighbouring registers stay untouched. Writes to addresses 6 and 7 check that invalid addresses are dropped. A word shifted while load enable stays high, followed by a fresh rising edge, separates edge-triggered commits from level-triggered ones. Toggling chip enable and the soft power-down bit tells the two sources of `pwr_down_o` apart. A cycle-accurate behavioural model compares every output on every cycle, which pins down the three-cycle latency and the single-cycle strobe width.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int unsigned WORD_W_DEF   = 32;
  localparam int unsigned ADDR_W_DEF   = 3;
  localparam int unsigned NUM_REGS_DEF = 6;
  localparam int unsigned SYNC_N_DEF   = 2;
  localparam int unsigned PD_REG_DEF   = 2;
  localparam int unsigned PD_BIT_DEF   = 5;

  typedef enum logic [1:0] {
    PIN_CLK = 2'd0,
    PIN_DAT = 2'd1,
    PIN_LE  = 2'd2,
    PIN_CE  = 2'd3
  } pin_idx_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q[0] <= '0;
    else         ff_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[s] <= '0;
      else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign sync_o = ff_q[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              le_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  logic              sclk_d_q, le_d_q;
  logic [WORD_W-1:0] shift_q;
  logic              sclk_rise;
  logic [WORD_W-1:0] shift_nxt;

  assign sclk_rise = sclk_i & ~sclk_d_q;
  assign shift_nxt = {shift_q[WORD_W-2:0], sdat_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      le_d_q   <= 1'b0;
      shift_q  <= '0;
    end else begin
      sclk_d_q <= sclk_i;
      le_d_q   <= le_i;
      if (sclk_rise) shift_q <= shift_nxt;
    end
  end

  // a bit landing in the same sample as the load edge is still included
  assign word_o   = sclk_rise ? shift_nxt : shift_q;
  assign commit_o = le_i & ~le_d_q;

  // R1
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_rise |=> $stable(shift_q));
  // R1
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_rise |=> shift_q[0] == $past(sdat_i));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned NUM_REGS = 6
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             commit_i,
  input  logic [WORD_W-1:0]                word_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  regs_o,
  output logic [NUM_REGS-1:0]              load_stb_o
);
  localparam logic [ADDR_W:0] NREG_L = NUM_REGS[ADDR_W:0];

  logic [ADDR_W-1:0]               addr;
  logic [NUM_REGS-1:0]             hit;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;
  logic [NUM_REGS-1:0]             stb_q;

  assign addr = word_i[ADDR_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] IDX = i[ADDR_W-1:0];
    assign hit[i] = commit_i && (addr == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[i] <= '0;
        stb_q[i]  <= 1'b0;
      end else begin
        stb_q[i] <= hit[i];
        if (hit[i]) regs_q[i] <= word_i;
      end
    end

    // R4
    untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_q[i] |-> regs_q[i] == $past(regs_q[i]));
  end

  assign regs_o     = regs_q;
  assign load_stb_o = stb_q;

  // R6
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stb_q));
  // R6
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q != '0) |-> $past(commit_i));
  // R5
  bad_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && ({1'b0, addr} >= NREG_L)) |=> (stb_q == '0) && $stable(regs_q));
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned WORD_W   = WORD_W_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned NUM_REGS = NUM_REGS_DEF,
  parameter int unsigned SYNC_N   = SYNC_N_DEF,
  parameter int unsigned PD_REG   = PD_REG_DEF,
  parameter int unsigned PD_BIT   = PD_BIT_DEF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         ser_clk_i,
  input  logic                         ser_dat_i,
  input  logic                         ser_le_i,
  input  logic                         chip_en_i,
  output logic [NUM_REGS*WORD_W-1:0]   cfg_flat_o,
  output logic [NUM_REGS-1:0]          load_stb_o,
  output logic                         pwr_down_o,
  output logic                         cp_tristate_o
);
  logic [3:0]                      pins_s;
  logic                            commit;
  logic [WORD_W-1:0]               word;
  logic [NUM_REGS-1:0][WORD_W-1:0] regs;

  pin_sync #(.WIDTH(4), .STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({chip_en_i, ser_le_i, ser_dat_i, ser_clk_i}),
    .sync_o  (pins_s)
  );

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (pins_s[PIN_CLK]),
    .sdat_i   (pins_s[PIN_DAT]),
    .le_i     (pins_s[PIN_LE]),
    .commit_o (commit),
    .word_o   (word)
  );

  cfg_reg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .word_i     (word),
    .regs_o     (regs),
    .load_stb_o (load_stb_o)
  );

  assign cfg_flat_o    = regs;
  assign cp_tristate_o = ~pins_s[PIN_CE];
  assign pwr_down_o    = ~pins_s[PIN_CE] | regs[PD_REG][PD_BIT];

  // R7
  tri_implies_pd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_tristate_o |-> pwr_down_o);
  // R8
  reset_pd_chk: assert property (@(posedge clk_i)
    !rst_ni |-> pwr_down_o && cp_tristate_o && (load_stb_o == '0));
endmodule

// File: tb/tb_cfg_serial_loader.sv
module tb_cfg_serial_loader;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_le_i = 1'b0, chip_en_i = 1'b0;
  logic [191:0] cfg_flat_o;
  logic [5:0]   load_stb_o;
  logic         pwr_down_o, cp_tristate_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  cfg_serial_loader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .ser_le_i(ser_le_i), .chip_en_i(chip_en_i), .cfg_flat_o(cfg_flat_o),
    .load_stb_o(load_stb_o), .pwr_down_o(pwr_down_o), .cp_tristate_o(cp_tristate_o)
  );

  // behavioural reference: pin history, newest at index 0
  bit          h_clk[5], h_dat[5], h_le[5], h_ce[5];
  logic [31:0] m_shift;
  logic [31:0] m_reg[6];
  logic [5:0]  m_stb;
  int          stb_seen = 0;

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 5; i++) begin h_clk[i] = 0; h_dat[i] = 0; h_le[i] = 0; h_ce[i] = 0; end
      m_shift = '0; m_stb = '0;
      for (int i = 0; i < 6; i++) m_reg[i] = '0;
    end else begin
      for (int i = 4; i > 0; i--) begin
        h_clk[i] = h_clk[i-1]; h_dat[i] = h_dat[i-1]; h_le[i] = h_le[i-1]; h_ce[i] = h_ce[i-1];
      end
      h_clk[0] = ser_clk_i; h_dat[0] = ser_dat_i; h_le[0] = ser_le_i; h_ce[0] = chip_en_i;
      m_stb = '0;
      if (h_clk[3] && !h_clk[4]) m_shift = {m_shift[30:0], h_dat[3]};
      if (h_le[3] && !h_le[4] && m_shift[2:0] < 3'd6) begin
        m_reg[m_shift[2:0]] = m_shift;
        m_stb[m_shift[2:0]] = 1'b1;
      end
      if (load_stb_o != 0) stb_seen++;
      begin
        logic [191:0] flat;
        for (int i = 0; i < 6; i++) flat[i*32 +: 32] = m_reg[i];
        chk(cfg_flat_o == flat, "R4 registers", cfg_flat_o, flat);
        chk(load_stb_o == m_stb, "R6 strobe", {186'd0, load_stb_o}, {186'd0, m_stb});
        chk(cp_tristate_o == !h_ce[2], "R7 tristate", {191'd0, cp_tristate_o}, {191'd0, !h_ce[2]});
        chk(pwr_down_o == (!h_ce[2] || m_reg[2][5]), "R7 power-down",
            {191'd0, pwr_down_o}, {191'd0, (!h_ce[2] || m_reg[2][5])});
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic shift_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      ser_dat_i = w[i];
      wait_clk(3);
      ser_clk_i = 1'b1;
      wait_clk(6);
      ser_clk_i = 1'b0;
      wait_clk(3);
    end
  endtask

  task automatic pulse_le();
    wait_clk(3);
    ser_le_i = 1'b1;
    wait_clk(6);
    ser_le_i = 1'b0;
    wait_clk(6);
  endtask

  function automatic logic [31:0] reg_of(input int k);
    return cfg_flat_o[k*32 +: 32];
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R8 reset state
    chk(cfg_flat_o == '0, "R8 regs zero", cfg_flat_o, '0);
    chk(pwr_down_o && cp_tristate_o, "R8 power-down", {190'd0, pwr_down_o, cp_tristate_o}, 192'd3);
    rst_ni = 1'b1;
    wait_clk(4);
    chip_en_i = 1'b1;
    wait_clk(4);
    chk(!pwr_down_o && !cp_tristate_o, "R7 released", {190'd0, pwr_down_o, cp_tristate_o}, '0);

    // R1 R3 distinct patterns to each register
    shift_word(32'h1234_5670); pulse_le();
    chk(reg_of(0) == 32'h1234_5670, "R3 reg0", reg_of(0), 32'h1234_5670);
    shift_word(32'h8000_0001); pulse_le();
    chk(reg_of(1) == 32'h8000_0001, "R1 msb first", reg_of(1), 32'h8000_0001);
    shift_word(32'h0F0F_0F02); pulse_le();
    shift_word(32'hAAAA_AAAB); pulse_le();
    shift_word(32'hAAAA_AAAC); pulse_le();
    shift_word(32'h5555_5555); pulse_le();
    chk(reg_of(5) == 32'h5555_5555, "R3 reg5", reg_of(5), 32'h5555_5555);
    chk(reg_of(0) == 32'h1234_5670, "R4 reg0 kept", reg_of(0), 32'h1234_5670);
    chk(reg_of(3) == 32'hAAAA_AAAB, "R4 reg3 kept", reg_of(3), 32'hAAAA_AAAB);

    // R5 invalid addresses
    stb_seen = 0;
    shift_word(32'hFFFF_FFFE); pulse_le();
    shift_word(32'hFFFF_FFFF); pulse_le();
    chk(stb_seen == 0, "R5 no strobe", stb_seen, 0);
    chk(reg_of(4) == 32'hAAAA_AAAC, "R5 reg4 unchanged", reg_of(4), 32'hAAAA_AAAC);
    chk(reg_of(2) == 32'h0F0F_0F02, "R5 reg2 unchanged", reg_of(2), 32'h0F0F_0F02);

    // R2 clocks while load enable held high
    shift_word(32'hCAFE_0001);
    wait_clk(3);
    ser_le_i = 1'b1;
    wait_clk(6);
    shift_word(32'hBEEF_0003);
    chk(reg_of(1) == 32'hCAFE_0001, "R2 first commit", reg_of(1), 32'hCAFE_0001);
    chk(reg_of(3) == 32'hAAAA_AAAB, "R2 no level commit", reg_of(3), 32'hAAAA_AAAB);
    ser_le_i = 1'b0;
    wait_clk(6);
    pulse_le();
    chk(reg_of(3) == 32'hBEEF_0003, "R2 next edge commits", reg_of(3), 32'hBEEF_0003);

    // R7 soft power-down bit in reg2 bit5
    shift_word(32'h0000_0022); pulse_le();
    chk(pwr_down_o && !cp_tristate_o, "R7 soft pd", {190'd0, pwr_down_o, cp_tristate_o}, 192'd2);
    shift_word(32'h0000_0002); pulse_le();
    chk(!pwr_down_o, "R7 soft pd clear", {191'd0, pwr_down_o}, '0);
    chip_en_i = 1'b0;
    wait_clk(4);
    chk(pwr_down_o && cp_tristate_o, "R7 chip enable low", {190'd0, pwr_down_o, cp_tristate_o}, 192'd3);
    chip_en_i = 1'b1;
    wait_clk(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule